// File: doc/BRIEF.md
# Wired Interrupt Aggregator

This block gathers a vector of peripheral interrupt lines into one wired interrupt towards a parent interrupt controller. Every input passes through a two-stage synchronizer. It is then turned into a pending event according to one trigger mode shared by the whole instance. The event is latched in a pending (cause) register. The pending bits that are not masked are ORed together into a registered output.

Software reaches four registers through a simple synchronous write port and a combinational read port:

- a cause register that shows pending sources and is cleared by writing zeros;
- a write-only set register that forces sources pending, so an event can be retriggered;
- a per-source mask;
- a control register that holds the trigger mode and a flag that keeps message-signalled generation off.

The usual driver flow is as follows. Software masks everything and clears cause. It picks the trigger mode once, then unmasks the sources it handles. On an interrupt it reads cause and ignores the masked bits.

Top module: `wired_irq_agg`

## Requirements
- R1: After reset, cause reads 0x00000000, mask reads 0xFFFFFFFF, control reads 0, and irq_out is 0.
- R2: Registers are decoded at byte offsets: cause 0x00, set-cause 0x08, mask 0x10, control 0x28. Reads are combinational from reg_addr. Reading set-cause returns zero.
- R3: A read of any other offset returns zero. A write to any other offset changes no register.
- R4: Only control bit 3 (trigger mode) and bit 5 (message-signalled generation off) are stored. All other control bits read as 0. Bit 5 has no effect on irq_out.
- R5: With control bit 3 at 0 (level mode), a cause bit is set on every cycle its synchronized input is 1. A held level therefore sets the bit again right after it is cleared.
- R6: With control bit 3 at 1 (edge mode), a cause bit is set only when its synchronized input is 1 and was 0 one cycle earlier. A held level does not set it again after a clear.
- R7: A write to cause clears each bit written 0 and keeps each bit written 1.
- R8: A write to set-cause sets each cause bit written 1 and leaves each bit written 0 unchanged.
- R9: When a hardware event and a software clear hit the same cause bit in one cycle, the bit ends up set.
- R10: A mask bit of 1 keeps its cause bit from reaching irq_out. A mask bit of 0 lets it through. Masking does not alter cause.
- R11: irq_out equals the OR of (cause AND NOT mask) as it stood one clock edge earlier.
- R12: An input change reaches the event logic after two synchronizer edges. A level asserted before edge k is visible in cause after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_irq | input | 32 | Peripheral interrupt inputs, asynchronous |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_out | output | 1 | Registered wired interrupt to the parent |

## Verification
Directed sequences cover the two trigger modes. A held level after a clear separates the mode in which the bit sets again (level) from the mode in which it stays clear (edge). Each register write polarity gets its own sequence: clear-by-zero, set-by-one, zero writes to set-cause, and ones writes to cause. Masking is exercised with a pending bit toggled masked and unmasked, which exposes the one-cycle registered lag of the output. A long random phase follows. It mixes sparse input toggles with random writes to all four registers and to stray offsets, mode switches included. A cycle-level reference in the bench is compared against the read data and irq_out on every cycle, so any slip in synchronizer latency or set-versus-clear priority shows up.

// File: rtl/wia_pkg.sv
package wia_pkg;
  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] OFF_PEND = 8'h00;
  localparam logic [REG_AW-1:0] OFF_FORCE = 8'h08;
  localparam logic [REG_AW-1:0] OFF_MASK = 8'h10;
  localparam logic [REG_AW-1:0] OFF_CTRL = 8'h28;

  localparam int unsigned CTRL_EDGE_BIT = 3;
  localparam int unsigned CTRL_NOMSG_BIT = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_FORCE,
    SEL_MASK,
    SEL_CTRL
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [REG_AW-1:0] a);
    case (a)
      OFF_PEND:  return SEL_PEND;
      OFF_FORCE: return SEL_FORCE;
      OFF_MASK:  return SEL_MASK;
      OFF_CTRL:  return SEL_CTRL;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/wia_src_detect.sv
module wia_src_detect #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             edge_mode,
  output logic [N_SRC-1:0] hw_evt
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [N_SRC-1:0] stage_q [SYNC_STAGES];
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] synced;

  function automatic logic [N_SRC-1:0] event_of(
    input logic [N_SRC-1:0] now_v,
    input logic [N_SRC-1:0] old_v,
    input logic             edge_sel
  );
    return edge_sel ? (now_v & ~old_v) : now_v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= src_i;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign synced = stage_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= synced;
  end

  assign hw_evt = event_of(synced, prev_q, edge_mode);

  if (SYNC_STAGES == 2) begin : g_lat_chk
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
    // R12: level-mode events follow the raw inputs two edges later
    p_sync_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && !edge_mode) |-> (hw_evt == $past(src_i, 2)));
  end

  // R6: in edge mode no event fires for an input that was already high
  p_edge_only_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode |-> ((hw_evt & prev_q) == '0));
endmodule

// File: rtl/wia_pend_bank.sv
module wia_pend_bank #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] hw_evt,
  input  logic             wr_pend,
  input  logic             wr_force,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] pend_q
);
  logic [N_SRC-1:0] pend_d;

  function automatic logic [N_SRC-1:0] next_pend(
    input logic [N_SRC-1:0] cur,
    input logic [N_SRC-1:0] evt,
    input logic             clr_wr,
    input logic             set_wr,
    input logic [N_SRC-1:0] d
  );
    logic [N_SRC-1:0] kept;
    kept = clr_wr ? (cur & d) : cur;
    return kept | (set_wr ? d : '0) | evt;
  endfunction

  assign pend_d = next_pend(pend_q, hw_evt, wr_pend, wr_force, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R9: a hardware event always lands, whatever software writes
  p_hw_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(hw_evt)) == $past(hw_evt)));
  // R8: set-cause ones appear in cause on the next edge
  p_force_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_force |=> ((pend_q & $past(wdata)) == $past(wdata)));
  // R7: without a cause write no pending bit is lost
  p_no_silent_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/wia_regfile.sv
module wia_regfile
  import wia_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [N_SRC-1:0]  wdata,
  input  logic [N_SRC-1:0]  pend_q,
  output logic [N_SRC-1:0]  rdata,
  output logic [N_SRC-1:0]  mask_q,
  output logic              edge_mode,
  output logic              wr_pend,
  output logic              wr_force
);
  reg_sel_e sel;
  logic     edge_q;
  logic     nomsg_q;
  logic     wr_mask;
  logic     wr_ctrl;
  logic [N_SRC-1:0] ctrl_view;

  assign sel      = decode_addr(addr);
  assign wr_pend  = wr_en && (sel == SEL_PEND);
  assign wr_force = wr_en && (sel == SEL_FORCE);
  assign wr_mask  = wr_en && (sel == SEL_MASK);
  assign wr_ctrl  = wr_en && (sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (wr_mask) mask_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q  <= 1'b0;
      nomsg_q <= 1'b0;
    end else if (wr_ctrl) begin
      edge_q  <= wdata[CTRL_EDGE_BIT];
      nomsg_q <= wdata[CTRL_NOMSG_BIT];
    end
  end

  assign edge_mode = edge_q;

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_EDGE_BIT]  = edge_q;
    ctrl_view[CTRL_NOMSG_BIT] = nomsg_q;
  end

  always_comb begin
    case (sel)
      SEL_PEND: rdata = pend_q;
      SEL_MASK: rdata = mask_q;
      SEL_CTRL: rdata = ctrl_view;
      default:  rdata = '0;
    endcase
  end

  // R3: stray offsets read as zero
  p_stray_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE || sel == SEL_FORCE) |-> (rdata == '0));
  // R3: a write elsewhere leaves mask alone
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> (mask_q == $past(mask_q)));
endmodule

// File: rtl/wired_irq_agg.sv
module wired_irq_agg
  import wia_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_irq,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [N_SRC-1:0]  reg_wdata,
  output logic [N_SRC-1:0]  reg_rdata,
  output logic              irq_out
);
  logic [N_SRC-1:0] hw_evt;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] mask_q;
  logic             edge_mode;
  logic             wr_pend;
  logic             wr_force;
  logic             irq_q;

  function automatic logic any_live(input logic [N_SRC-1:0] p, input logic [N_SRC-1:0] m);
    return |(p & ~m);
  endfunction

  wia_src_detect #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk(clk), .rst_n(rst_n), .src_i(src_irq), .edge_mode(edge_mode), .hw_evt(hw_evt)
  );

  wia_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .wr_pend(wr_pend),
    .wr_force(wr_force), .wdata(reg_wdata), .pend_q(pend_q)
  );

  wia_regfile #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .pend_q(pend_q), .rdata(reg_rdata), .mask_q(mask_q), .edge_mode(edge_mode),
    .wr_pend(wr_pend), .wr_force(wr_force)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_live(pend_q, mask_q);
  end

  assign irq_out = irq_q;

  // R11: output follows unmasked pending one edge late
  p_irq_lag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == |($past(pend_q) & ~$past(mask_q))));
  // R10: all-masked means no interrupt on the next edge
  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |=> !irq_out);
endmodule

// File: tb/wired_irq_agg_test.sv
module wired_irq_agg_test;
  localparam int PERIOD = 10;
  localparam int MAX_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_irq = '0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  wired_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always #(PERIOD/2) clk = ~clk;

  // Reference: two-stage sync, previous-sample edge detect, set beats clear.
  logic [31:0] m_a, m_b, m_old, m_pend, m_msk;
  logic        m_edge, m_nomsg, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a <= 0; m_b <= 0; m_old <= 0; m_pend <= 0; m_msk <= 32'hFFFF_FFFF;
      m_edge <= 0; m_nomsg <= 0; m_irq <= 0;
    end else begin
      logic [31:0] ev, np;
      ev = m_b;
      if (m_edge) ev = m_b & ~m_old;
      np = m_pend;
      if (reg_wr_en && reg_addr == 8'h00) np = np & reg_wdata;
      if (reg_wr_en && reg_addr == 8'h08) np = np | reg_wdata;
      np = np | ev;
      m_irq <= (m_pend & ~m_msk) != 0;
      m_a <= src_irq; m_b <= m_a; m_old <= m_b; m_pend <= np;
      if (reg_wr_en && reg_addr == 8'h10) m_msk <= reg_wdata;
      if (reg_wr_en && reg_addr == 8'h28) begin
        m_edge <= reg_wdata[3]; m_nomsg <= reg_wdata[5];
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'h00) return m_pend;
    if (a == 8'h10) return m_msk;
    if (a == 8'h28) return {26'd0, m_nomsg, 1'b0, m_edge, 3'd0};
    return 32'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference, at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R11 irq_out vs model", {31'd0, irq_out}, {31'd0, m_irq});
      check("R2 read vs model", reg_rdata, model_read(reg_addr));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    rst_n = 1'b1;
    step(1);
    rd("R1 cause reset", 8'h00, 32'h0);
    rd("R1 mask reset", 8'h10, 32'hFFFF_FFFF);
    rd("R1 control reset", 8'h28, 32'h0);
    check("R1 irq reset", {31'd0, irq_out}, 32'd0);
    rd("R2 set-cause reads zero", 8'h08, 32'h0);

    // Level mode: held input re-sets after clear
    wr(8'h10, 32'hFFFF_FFFE);
    src_irq[0] = 1'b1;
    step(5);
    rd("R5 level sets cause", 8'h00, 32'h1);
    check("R11 irq on unmasked pending", {31'd0, irq_out}, 32'd1);
    wr(8'h00, 32'h0);
    rd("R9 set wins over clear, level re-set R5", 8'h00, 32'h1);
    src_irq[0] = 1'b0;
    step(3);
    wr(8'h00, 32'h0);
    step(1);
    rd("R7 write zero clears", 8'h00, 32'h0);

    // Edge mode: held input stays cleared
    wr(8'h28, 32'h0000_0028);
    rd("R4 control bits stored", 8'h28, 32'h28);
    src_irq[1] = 1'b1;
    step(5);
    rd("R6 rising edge sets", 8'h00, 32'h2);
    wr(8'h00, 32'h0);
    step(4);
    rd("R6 held level no re-set", 8'h00, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);
    rd("R4 other control bits zero", 8'h28, 32'h28);

    // Set-cause and write polarity
    wr(8'h08, 32'h0000_0080);
    rd("R8 force sets bit", 8'h00, 32'h80);
    wr(8'h08, 32'h0);
    rd("R8 zero write no effect", 8'h00, 32'h80);
    wr(8'h00, 32'hFFFF_FFFF);
    rd("R7 ones keep bits", 8'h00, 32'h80);
    step(2);
    check("R10 masked pending no irq", {31'd0, irq_out}, 32'd0);
    wr(8'h10, 32'hFFFF_FF7E);
    check("R11 registered lag", {31'd0, irq_out}, 32'd0);
    step(1);
    check("R11 irq after lag", {31'd0, irq_out}, 32'd1);
    rd("R10 mask leaves cause", 8'h00, 32'h80);
    wr(8'h28, 32'h0000_0008);
    step(2);
    check("R4 nomsg bit has no effect on irq", {31'd0, irq_out}, 32'd1);

    // Stray offsets
    wr(8'h04, 32'hFFFF_FFFF);
    rd("R3 stray read zero", 8'h04, 32'h0);
    rd("R3 stray write ignored mask", 8'h10, 32'hFFFF_FF7E);
    rd("R3 stray write ignored cause", 8'h00, 32'h80);

    // Random phase, checked every cycle by the monitor
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk); #1;
      src_irq = src_irq ^ ($urandom & $urandom & $urandom);
      case ($urandom_range(0, 4))
        0: reg_addr = 8'h00;
        1: reg_addr = 8'h08;
        2: reg_addr = 8'h10;
        3: reg_addr = 8'h28;
        default: reg_addr = 8'($urandom);
      endcase
      reg_wr_en = ($urandom_range(0, 3) == 0);
      reg_wdata = (reg_addr == 8'h08) ? ($urandom & $urandom) : $urandom;
    end
    @(negedge clk); #1;
    reg_wr_en = 1'b0;
    step(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * MAX_CYC);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule